// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block is the digital core of a processor supervisor. It merges four reset causes into one reset: the supply-fail flag from an external comparator (already synchronized), an active-low push-button input, a watchdog that expires when the processor stops strobing, and power-up. It drives a complementary pair of reset outputs. Whenever the last cause clears, the reset is held for a fixed stretch time so that the supply and the processor can settle.

All durations count in millisecond ticks. A prescaler derives these ticks from the clock, and the parameter `CYC_PER_MS` sets how many clock cycles make one tick. The push-button and strobe inputs each pass through a two-flop synchronizer. The push-button is then debounced. Falling edges of the strobe restart the watchdog. The watchdog has no disable path. It ignores strobes while reset is active and begins a fresh full period on the cycle that reset releases. The block has no data stream, so every pin is a plain level signal.

Top module: `sup_reset_ctrl`

## Requirements
- R1: `rst_o` goes high one cycle after `supply_fail_i` is high. It goes high at once, without waiting for a clock edge, while `por_n` is low. It stays high through the power-up stretch after `por_n` releases.
- R2: Once every cause has cleared, `rst_o` stays high for at least `STRETCH_MS` (250) ticks and falls within 251 ticks plus two cycles.
- R3: `wd_sel_i` picks the watchdog period: 2'b00 gives 150 ms, 2'b01 gives 610 ms, and 2'b10 or 2'b11 gives 1200 ms. With no strobe edge, reset asserts between (period-1) ticks and period ticks plus three cycles after reset releases.
- R4: Only a high-to-low transition of `strobe_n_i` restarts the watchdog. A strobe held steadily low or steadily high does not prevent a timeout.
- R5: Strobe edges are ignored while `rst_o` is high. The watchdog count restarts from zero on the cycle that reset releases.
- R6: The watchdog cannot be disabled. An expiry asserts `rst_o` on the next cycle, and the stretch of R2 follows.
- R7: A push-button low of 20 ticks, plus the synchronizer delay, asserts reset. A low shorter than 19 ticks is ignored. Reset releases 20 ticks (the debounce) plus the R2 stretch after the button returns high.
- R8: `rst_n_o` is always the exact complement of `rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; loads the stretch timer |
| supply_fail_i | input | 1 | Synchronized supply-fail flag, active high |
| pb_n_i | input | 1 | Push-button input, active low, asynchronous |
| strobe_n_i | input | 1 | Watchdog strobe input; falling edges restart the timer |
| wd_sel_i | input | 2 | Watchdog period select (00 short, 01 middle, 1x long) |
| rst_o | output | 1 | Reset, active high |
| rst_n_o | output | 1 | Reset, active low, complement of `rst_o` |

## Verification
Four properties are checked on every cycle. The outputs must stay complementary. A supply fail, a debounced press or a watchdog expiry must raise reset on the next cycle. Reset may never fall before the stretch time has passed since the last cause. The watchdog must never report expiry during reset. The bench's scenarios are needed for the rest: the exact period for each select code, that steady strobe levels do not count as kicks, that periodic kicks keep reset low, that short button glitches are rejected, and the release time after a button press.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    WD_SHORT = 2'b00,
    WD_MID   = 2'b01,
    WD_LONG  = 2'b10
  } wd_sel_e;
endpackage

// File: rtl/sup_tick_gen.sv
module sup_tick_gen #(
  parameter int CYC_PER_MS = 125000
) (
  input  logic clk,
  input  logic por_n,
  output logic tick_o
);
  generate
    if (CYC_PER_MS <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(CYC_PER_MS);
      localparam logic [W-1:0] LAST = W'(CYC_PER_MS - 1);
      logic [W-1:0] cnt_q;
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/sup_sync_in.sv
module sup_sync_in #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-2:0], d_i};
  end
  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/sup_debounce.sv
module sup_debounce #(
  parameter int DEB_MS = 20
) (
  input  logic clk,
  input  logic por_n,
  input  logic tick_i,
  input  logic level_n_i,
  output logic pressed_o
);
  localparam int W = $clog2(DEB_MS + 1);
  localparam logic [W-1:0] LAST = W'(DEB_MS - 1);
  logic [W-1:0] cnt_q;
  logic         pressed_q;
  logic         differs;

  // the synchronized level disagrees with the debounced state
  assign differs = (level_n_i == pressed_q);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q     <= '0;
      pressed_q <= 1'b0;
    end else if (!differs) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        pressed_q <= ~pressed_q;
        cnt_q     <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
  assign pressed_o = pressed_q;
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog
  import sup_pkg::*;
#(
  parameter int SHORT_MS = 150,
  parameter int MID_MS   = 610,
  parameter int LONG_MS  = 1200
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tick_i,
  input  logic       strobe_n_i,
  input  logic       hold_i,
  input  logic [1:0] sel_i,
  output logic       expired_o
);
  localparam int W = $clog2(LONG_MS + 1);
  logic [W-1:0] cnt_q, last;
  logic         prev_q, fall, expired_q;

  always_comb begin
    case (wd_sel_e'(sel_i))
      WD_SHORT: last = W'(SHORT_MS - 1);
      WD_MID:   last = W'(MID_MS - 1);
      default:  last = W'(LONG_MS - 1);
    endcase
  end

  assign fall = prev_q & ~strobe_n_i;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      prev_q    <= 1'b1;
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else begin
      prev_q <= strobe_n_i;
      if (hold_i || fall) begin
        cnt_q     <= '0;
        expired_q <= 1'b0;
      end else if (tick_i && cnt_q == last) begin
        cnt_q     <= '0;
        expired_q <= 1'b1;
      end else begin
        if (tick_i) cnt_q <= cnt_q + 1'b1;
        expired_q <= 1'b0;
      end
    end
  end
  assign expired_o = expired_q;
endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
  parameter int STRETCH_MS = 250
) (
  input  logic clk,
  input  logic por_n,
  input  logic tick_i,
  input  logic cause_i,
  output logic rst_o
);
  localparam int LOAD = STRETCH_MS + 1;
  localparam int W = $clog2(LOAD + 1);
  logic [W-1:0] cnt_q, cnt_d;
  logic         rst_q;

  always_comb begin
    if (cause_i)                     cnt_d = W'(LOAD);
    else if (tick_i && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= W'(LOAD);
      rst_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      rst_q <= (cnt_d != '0);
    end
  end
  assign rst_o = rst_q;
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int CYC_PER_MS  = 125000,
  parameter int SYNC_STAGES = 2,
  parameter int DEB_MS      = 20,
  parameter int STRETCH_MS  = 250,
  parameter int WD_SHORT_MS = 150,
  parameter int WD_MID_MS   = 610,
  parameter int WD_LONG_MS  = 1200
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       supply_fail_i,
  input  logic       pb_n_i,
  input  logic       strobe_n_i,
  input  logic [1:0] wd_sel_i,
  output logic       rst_o,
  output logic       rst_n_o
);
  logic tick, pb_sync, st_sync, pb_pressed, wd_expired, rst_q, cause;

  sup_tick_gen #(.CYC_PER_MS(CYC_PER_MS)) tick_i (
    .clk(clk), .por_n(por_n), .tick_o(tick));

  sup_sync_in #(.STAGES(SYNC_STAGES)) pb_sync_i (
    .clk(clk), .por_n(por_n), .d_i(pb_n_i), .q_o(pb_sync));

  sup_sync_in #(.STAGES(SYNC_STAGES)) st_sync_i (
    .clk(clk), .por_n(por_n), .d_i(strobe_n_i), .q_o(st_sync));

  sup_debounce #(.DEB_MS(DEB_MS)) deb_i (
    .clk(clk), .por_n(por_n), .tick_i(tick),
    .level_n_i(pb_sync), .pressed_o(pb_pressed));

  sup_watchdog #(.SHORT_MS(WD_SHORT_MS), .MID_MS(WD_MID_MS),
                 .LONG_MS(WD_LONG_MS)) wd_i (
    .clk(clk), .por_n(por_n), .tick_i(tick), .strobe_n_i(st_sync),
    .hold_i(rst_q), .sel_i(wd_sel_i), .expired_o(wd_expired));

  assign cause = supply_fail_i | pb_pressed | wd_expired;

  sup_stretch #(.STRETCH_MS(STRETCH_MS)) str_i (
    .clk(clk), .por_n(por_n), .tick_i(tick),
    .cause_i(cause), .rst_o(rst_q));

  assign rst_o   = rst_q;
  assign rst_n_o = ~rst_q;
endmodule

// File: rtl/sup_reset_ctrl_chk.sv
module sup_reset_ctrl_chk #(
  parameter int CYC_PER_MS = 125000,
  parameter int STRETCH_MS = 250
) (
  input logic clk,
  input logic por_n,
  input logic supply_fail_i,
  input logic pb_pressed_i,
  input logic wd_expired_i,
  input logic rst_o,
  input logic rst_n_o
);
  localparam int MIN_CYC = STRETCH_MS * CYC_PER_MS;
  localparam int W = $clog2(MIN_CYC + 2);
  logic [W-1:0] quiet_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) quiet_q <= '0;
    else if (supply_fail_i || pb_pressed_i || wd_expired_i) quiet_q <= '0;
    else if (quiet_q != W'(MIN_CYC + 1)) quiet_q <= quiet_q + 1'b1;
  end

  AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (!por_n)
    rst_n_o == !rst_o); // R8
  AST_SUPPLY_FAIL_RESET: assert property (@(posedge clk) disable iff (!por_n)
    supply_fail_i |=> rst_o); // R1
  AST_MIN_STRETCH: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_o) |-> (quiet_q >= W'(MIN_CYC))); // R2
  AST_WD_EXPIRY_RESET: assert property (@(posedge clk) disable iff (!por_n)
    wd_expired_i |=> rst_o); // R6
  AST_WD_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
    rst_o |=> !wd_expired_i); // R5
  AST_BUTTON_RESET: assert property (@(posedge clk) disable iff (!por_n)
    pb_pressed_i |=> rst_o); // R7
endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk #(
  .CYC_PER_MS(CYC_PER_MS), .STRETCH_MS(STRETCH_MS)
) chk_i (
  .clk(clk), .por_n(por_n), .supply_fail_i(supply_fail_i),
  .pb_pressed_i(pb_pressed), .wd_expired_i(wd_expired),
  .rst_o(rst_o), .rst_n_o(rst_n_o)
);

// File: tb/sup_reset_ctrl_tb_top.sv
`timescale 1ns/1ps
module sup_reset_ctrl_tb_top;
  localparam int P = 2;
  localparam int N_VEC = 4;
  localparam logic [1:0] SEL_V [N_VEC] = '{2'b00, 2'b01, 2'b10, 2'b11};
  localparam int         MS_V  [N_VEC] = '{150, 610, 1200, 1200};

  logic clk = 1'b0, por_n = 1'b0, sf = 1'b0, pb_n = 1'b1;
  logic man_st = 1'b1, kick_lvl = 1'b1, kick_en = 1'b0;
  logic [1:0] sel = 2'b00;
  logic rst_o, rst_n_o, strobe_n;
  int checks = 0, fails = 0, cmp_err = 0, kcnt = 0;

  assign strobe_n = kick_en ? kick_lvl : man_st;
  always #4 clk = ~clk;

  sup_reset_ctrl #(.CYC_PER_MS(P)) dut_i (
    .clk(clk), .por_n(por_n), .supply_fail_i(sf), .pb_n_i(pb_n),
    .strobe_n_i(strobe_n), .wd_sel_i(sel), .rst_o(rst_o), .rst_n_o(rst_n_o));

  always @(negedge clk) begin
    if (rst_n_o !== ~rst_o) cmp_err++;
    if (kick_en) begin
      kcnt++;
      if (kcnt == 100) kick_lvl = 1'b0;
      if (kcnt >= 104) begin kick_lvl = 1'b1; kcnt = 0; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_lo, input int exp_hi);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, exp_lo, exp_hi);
    end
  endtask

  task automatic wait_lvl(input logic lvl, input int maxc, output int n);
    n = 0;
    while (rst_o !== lvl && n < maxc) begin @(negedge clk); n++; end
  endtask

  task automatic win(input logic lvl, input int lo, input int hi, input string req);
    int n;
    wait_lvl(lvl, hi + 50, n);
    chk(n >= lo && n <= hi, req, n, lo, hi);
  endtask

  initial begin
    int n;
    bit stayed;
    repeat (5) @(negedge clk);
    chk(rst_o === 1'b1, "R1 por", int'(rst_o), 1, 1);
    chk(rst_n_o === 1'b0, "R8 por", int'(rst_n_o), 0, 0);
    por_n = 1'b1;
    // vector table: select code and its period
    for (int i = 0; i < N_VEC; i++) begin
      sel = SEL_V[i];
      win(1'b0, 250*P, 251*P + 2, "R2 stretch");
      win(1'b1, (MS_V[i]-1)*P, MS_V[i]*P + 3, "R3 period");
    end
    // R5: strobe edges during reset ignored, fresh period after release
    sel = 2'b00;
    repeat (3) begin
      repeat (20) @(negedge clk); man_st = 1'b0;
      repeat (20) @(negedge clk); man_st = 1'b1;
    end
    win(1'b0, 250*P - 120, 251*P + 2, "R5 release");
    win(1'b1, 149*P, 150*P + 3, "R5 fresh period");
    // R4: periodic falling edges keep reset low
    wait_lvl(1'b0, 600, n);
    kick_en = 1'b1; kcnt = 0;
    stayed = 1'b1;
    repeat (1200) begin @(negedge clk); if (rst_o !== 1'b0) stayed = 1'b0; end
    chk(stayed, "R4 kicks hold off", int'(!stayed), 0, 0);
    man_st = 1'b0; kick_en = 1'b0;
    win(1'b1, 149*P, 150*P + 5, "R4 steady low");
    man_st = 1'b1;
    win(1'b0, 250*P, 251*P + 2, "R6 stretch");
    win(1'b1, 149*P, 150*P + 3, "R4 steady high");
    // R1/R2: supply fail
    wait_lvl(1'b0, 600, n);
    kick_en = 1'b1; kcnt = 0;
    repeat (20) @(negedge clk);
    sf = 1'b1;
    @(negedge clk);
    chk(rst_o === 1'b1, "R1 supply fail", int'(rst_o), 1, 1);
    repeat (10) @(negedge clk);
    sf = 1'b0;
    win(1'b0, 250*P, 251*P + 3, "R2 after supply");
    // R7: short glitch ignored, long press recognized
    repeat (10) @(negedge clk);
    pb_n = 1'b0; repeat (30) @(negedge clk); pb_n = 1'b1;
    stayed = 1'b1;
    repeat (80) begin @(negedge clk); if (rst_o !== 1'b0) stayed = 1'b0; end
    chk(stayed, "R7 glitch ignored", int'(!stayed), 0, 0);
    pb_n = 1'b0; repeat (50) @(negedge clk);
    chk(rst_o === 1'b1, "R7 press", int'(rst_o), 1, 1);
    pb_n = 1'b1;
    win(1'b0, 269*P, 272*P + 4, "R7 release");
    // R1: asynchronous power-on reset mid-run
    repeat (30) @(negedge clk);
    por_n = 1'b0;
    #1;
    chk(rst_o === 1'b1, "R1 async por", int'(rst_o), 1, 1);
    @(negedge clk); por_n = 1'b1; kick_en = 1'b0;
    repeat (5) @(negedge clk);
    chk(cmp_err == 0, "R8 complement", cmp_err, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule